// File: doc/BRIEF.md
# Four-Way Instruction Translation Cache Recency Tracker

This block holds the replacement state for a fully associative instruction translation cache with four slots. The state is a 6-bit pairwise-order field that lives in the top six bits (31 down to 26) of the memory-management control register. Each bit records the relative age of one pair of slots. A lookup hit on a slot rewrites some of those bits through an AND mask and then an OR mask. Software can overwrite the whole field at any time.

When the instruction cache misses and the unified translation cache supplies the entry, the refill logic raises a fill request. The block then names the slot to overwrite, and in the same clock edge it records that slot as the most recently used. The victim is picked by comparing three bits of the field against a fixed pattern for each slot. If the field holds a pattern that none of the four slots accepts, the block raises an error flag and names slot 0.

Top module: `itlb_lru_tracker`

## Requirements
- R1: After reset the field reads 6'b000000, the victim index is 3, the error flag is low and victim_vld is low.
- R2: lru_field[5] is control-register bit 31 and lru_field[0] is bit 26. When cr_wr_en is high, cr_wr_data is loaded into the field at the next edge. A write takes precedence over a hit and over a fill in the same cycle.
- R3: A hit on slot 0 clears field bits 5, 4 and 3 and leaves bits 2..0 unchanged.
- R4: A hit on slot 1 sets bit 5, clears bits 2 and 1, and leaves bits 4, 3 and 0 unchanged.
- R5: A hit on slot 2 sets bits 4 and 2, clears bit 0, and leaves bits 5, 3 and 1 unchanged.
- R6: A hit on slot 3 sets bits 3, 1 and 0 and leaves bits 5, 4 and 2 unchanged.
- R7: The victim is checked in order 0, 1, 2, 3, and the first match wins:
  - slot 0 if bits 5, 4 and 3 are all 1;
  - slot 1 if bit 5 is 0, bit 2 is 0 and bit 1 is 1;
  - slot 2 if bit 4 is 0, bit 2 is 0 and bit 0 is 1;
  - slot 3 if bits 3, 1 and 0 are all 0.
- R8: When no slot pattern matches, lru_err is high and victim_idx is 0.
- R9: victim_vld follows fill_req in the same cycle. A fill updates the field as a hit on the slot named by victim_idx in that cycle, and it takes precedence over a hit in the same cycle.
- R10: In a cycle with no write, hit or fill, the field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | Lookup hit strobe |
| hit_idx | input | 2 | Slot that hit |
| cr_wr_en | input | 1 | Software write of the recency field |
| cr_wr_data | input | 6 | Value for control-register bits 31..26 |
| fill_req | input | 1 | Refill from the unified cache: nominate and commit a victim |
| victim_vld | output | 1 | Victim index is being consumed this cycle |
| victim_idx | output | 2 | Slot to overwrite on refill |
| lru_err | output | 1 | Field holds a pattern that no slot matches |
| lru_field | output | 6 | Current recency field (control-register bits 31..26) |

## Verification
The assertions assume that hit_idx is meaningful only while hit_vld is high. They also assume that a fill and a hit may arrive together but are then resolved by the stated precedence. Software may write any 6-bit value, including inconsistent ones. The stimulus therefore deliberately loads patterns that no slot accepts, to exercise the error path, and it drives simultaneous write, fill and hit strobes to check precedence. All other strobes are issued one per cycle on the falling edge, so every registered update is observed exactly one edge later.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
  localparam int unsigned WAYS  = 4;
  localparam int unsigned IDX_W = $clog2(WAYS);
  localparam int unsigned LRU_W = WAYS * (WAYS - 1) / 2;

  typedef logic [LRU_W-1:0] lru_t;
  typedef logic [IDX_W-1:0] way_t;

  // Bits a hit on a given slot forces low
  function automatic lru_t lru_and_mask(way_t w);
    case (w)
      2'd0:    return 6'b000111;
      2'd1:    return 6'b111001;
      2'd2:    return 6'b111110;
      default: return 6'b111111;
    endcase
  endfunction

  // Bits a hit on a given slot forces high
  function automatic lru_t lru_or_mask(way_t w);
    case (w)
      2'd0:    return 6'b000000;
      2'd1:    return 6'b100000;
      2'd2:    return 6'b010100;
      default: return 6'b001011;
    endcase
  endfunction

  function automatic lru_t lru_touch(lru_t s, way_t w);
    return (s & lru_and_mask(w)) | lru_or_mask(w);
  endfunction

  // One bit per slot: its victim pattern holds on s
  function automatic logic [WAYS-1:0] lru_match(lru_t s);
    logic [WAYS-1:0] m;
    m[0] =  s[5] &  s[4] &  s[3];
    m[1] = ~s[5] & ~s[2] &  s[1];
    m[2] = ~s[4] & ~s[2] &  s[0];
    m[3] = ~s[3] & ~s[1] & ~s[0];
    return m;
  endfunction
endpackage

// File: rtl/itlb_lru_next.sv
module itlb_lru_next
  import itlb_lru_pkg::*;
(
  input  lru_t cur,
  input  logic wr_en,
  input  lru_t wr_data,
  input  logic touch_en,
  input  way_t touch_way,
  output lru_t nxt,
  output logic load
);
  always_comb begin
    nxt = cur;
    if (wr_en)         nxt = wr_data;
    else if (touch_en) nxt = lru_touch(cur, touch_way);
  end

  assign load = wr_en | touch_en;
endmodule

// File: rtl/itlb_victim_sel.sv
module itlb_victim_sel
  import itlb_lru_pkg::*;
(
  input  lru_t            state,
  output way_t            victim,
  output logic            err,
  output logic [WAYS-1:0] pick_oh
);
  logic [WAYS-1:0] match;

  assign match = lru_match(state);

  // Lowest-numbered matching slot wins
  always_comb begin
    pick_oh = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i] && pick_oh == '0) pick_oh[i] = 1'b1;
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (pick_oh[i]) victim = way_t'(i);
    end
  end

  assign err = ~|match;
endmodule

// File: rtl/itlb_lru_reg.sv
module itlb_lru_reg #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= d;
  end
endmodule

// File: rtl/itlb_lru_tracker.sv
module itlb_lru_tracker
  import itlb_lru_pkg::*;
#(
  parameter logic [5:0] RST_FIELD = 6'b000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_vld,
  input  logic [1:0] hit_idx,
  input  logic       cr_wr_en,
  input  logic [5:0] cr_wr_data,
  input  logic       fill_req,
  output logic       victim_vld,
  output logic [1:0] victim_idx,
  output logic       lru_err,
  output logic [5:0] lru_field
);
  lru_t            state_q;
  lru_t            state_d;
  logic            state_load;
  way_t            victim_w;
  logic            err_w;
  logic [WAYS-1:0] pick_oh;
  logic            touch_en;
  way_t            touch_way;

  // Fill takes precedence over a plain hit
  assign touch_en  = fill_req | hit_vld;
  assign touch_way = fill_req ? victim_w : hit_idx;

  itlb_victim_sel u_sel (
    .state   (state_q),
    .victim  (victim_w),
    .err     (err_w),
    .pick_oh (pick_oh)
  );

  itlb_lru_next u_next (
    .cur       (state_q),
    .wr_en     (cr_wr_en),
    .wr_data   (cr_wr_data),
    .touch_en  (touch_en),
    .touch_way (touch_way),
    .nxt       (state_d),
    .load      (state_load)
  );

  itlb_lru_reg #(.W(LRU_W), .RST_VAL(RST_FIELD)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (state_load),
    .d     (state_d),
    .q     (state_q)
  );

  assign victim_vld = fill_req;
  assign victim_idx = victim_w;
  assign lru_err    = err_w;
  assign lru_field  = state_q;
endmodule

// File: rtl/itlb_lru_tracker_chk.sv
module itlb_lru_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hit_vld,
  input logic [1:0] hit_idx,
  input logic       cr_wr_en,
  input logic [5:0] cr_wr_data,
  input logic       fill_req,
  input logic [1:0] victim_idx,
  input logic       lru_err,
  input logic [5:0] lru_field,
  input logic [3:0] pick_oh
);
  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_wr_en |=> lru_field == $past(cr_wr_data));

  // R3
  hit0_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld && !cr_wr_en && !fill_req && hit_idx == 2'd0)
    |=> (lru_field[5:3] == 3'b000) && (lru_field[2:0] == $past(lru_field[2:0])));

  // R6
  hit3_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld && !cr_wr_en && !fill_req && hit_idx == 2'd3)
    |=> lru_field[3] && lru_field[1] && lru_field[0]
        && lru_field[5:4] == $past(lru_field[5:4]) && lru_field[2] == $past(lru_field[2]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_vld && !cr_wr_en && !fill_req) |=> $stable(lru_field));

  // R7
  pick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh) && (!lru_err -> $countones(pick_oh) == 1));

  // R8
  err_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lru_err |-> victim_idx == 2'd0);

  // R9
  fill_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !cr_wr_en) |=> lru_err || victim_idx != $past(victim_idx));
endmodule

bind itlb_lru_tracker itlb_lru_tracker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_vld    (hit_vld),
  .hit_idx    (hit_idx),
  .cr_wr_en   (cr_wr_en),
  .cr_wr_data (cr_wr_data),
  .fill_req   (fill_req),
  .victim_idx (victim_idx),
  .lru_err    (lru_err),
  .lru_field  (lru_field),
  .pick_oh    (pick_oh)
);

// File: tb/itlb_lru_tracker_tb.sv
module itlb_lru_tracker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit_vld = 1'b0;
  logic [1:0] hit_idx = '0;
  logic       cr_wr_en = 1'b0;
  logic [5:0] cr_wr_data = '0;
  logic       fill_req = 1'b0;
  logic       victim_vld;
  logic [1:0] victim_idx;
  logic       lru_err;
  logic [5:0] lru_field;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  itlb_lru_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_idx(hit_idx),
    .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data), .fill_req(fill_req),
    .victim_vld(victim_vld), .victim_idx(victim_idx), .lru_err(lru_err),
    .lru_field(lru_field)
  );

  // op: 0 idle, 1 hit (arg[1:0]), 2 write (arg), 3 fill
  typedef struct packed {
    logic [1:0] op;
    logic [5:0] arg;
    logic [5:0] f;
    logic [1:0] v;
    logic       e;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 6'd3,      6'b001011, 2'd1, 1'b0},  // R6 R7
    '{2'd1, 6'd1,      6'b101001, 2'd2, 1'b0},  // R4
    '{2'd1, 6'd2,      6'b111100, 2'd0, 1'b0},  // R5
    '{2'd1, 6'd0,      6'b000100, 2'd3, 1'b0},  // R3
    '{2'd0, 6'd0,      6'b000100, 2'd3, 1'b0},  // R10
    '{2'd3, 6'd0,      6'b001111, 2'd0, 1'b1},  // R9 R8
    '{2'd2, 6'b000111, 6'b000111, 2'd0, 1'b1},  // R2 R8
    '{2'd3, 6'd0,      6'b000111, 2'd0, 1'b1},  // R9
    '{2'd2, 6'b111000, 6'b111000, 2'd0, 1'b0},  // R2 R7
    '{2'd1, 6'd2,      6'b111100, 2'd0, 1'b0},  // R5
    '{2'd1, 6'd1,      6'b111000, 2'd0, 1'b0},  // R4
    '{2'd1, 6'd0,      6'b000000, 2'd3, 1'b0},  // R3
    '{2'd3, 6'd0,      6'b001011, 2'd1, 1'b0},  // R9
    '{2'd3, 6'd0,      6'b101001, 2'd2, 1'b0},  // R9
    '{2'd3, 6'd0,      6'b111100, 2'd0, 1'b0},  // R9
    '{2'd3, 6'd0,      6'b000100, 2'd3, 1'b0},  // R9
    '{2'd2, 6'b010101, 6'b010101, 2'd0, 1'b1},  // R8
    '{2'd1, 6'd3,      6'b011111, 2'd0, 1'b1},  // R6 R8
    '{2'd2, 6'b101110, 6'b101110, 2'd0, 1'b1},  // R8
    '{2'd1, 6'd0,      6'b000110, 2'd0, 1'b1},  // R3 R8
    '{2'd2, 6'b000010, 6'b000010, 2'd1, 1'b0},  // R7
    '{2'd2, 6'b000001, 6'b000001, 2'd2, 1'b0}   // R7
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    hit_vld = 1'b0; fill_req = 1'b0; cr_wr_en = 1'b0;
    hit_idx = '0; cr_wr_data = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 field", lru_field, 0);
    check("R1 victim", victim_idx, 3);
    check("R1 err", lru_err, 0);
    check("R1 vld", victim_vld, 0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd1: begin hit_vld = 1'b1; hit_idx = VECS[i].arg[1:0]; end
        2'd2: begin cr_wr_en = 1'b1; cr_wr_data = VECS[i].arg; end
        2'd3: fill_req = 1'b1;
        default: ;
      endcase
      @(negedge clk);
      idle_inputs();
      check($sformatf("R2-R10 vec%0d field", i), lru_field, VECS[i].f);
      check($sformatf("R7 vec%0d victim", i), victim_idx, VECS[i].v);
      check($sformatf("R8 vec%0d err", i), lru_err, VECS[i].e);
    end

    // R9: fill beats hit, victim_vld same cycle. State now 000001, victim 2.
    cr_wr_en = 1'b1; cr_wr_data = 6'b000000;
    @(negedge clk);
    idle_inputs();
    fill_req = 1'b1; hit_vld = 1'b1; hit_idx = 2'd0;
    #1;
    check("R9 vld", victim_vld, 1);
    check("R9 victim", victim_idx, 3);
    @(negedge clk);
    idle_inputs();
    check("R9 fill over hit", lru_field, 6'b001011);

    // R2: write beats fill and hit
    cr_wr_en = 1'b1; cr_wr_data = 6'b111000;
    fill_req = 1'b1; hit_vld = 1'b1; hit_idx = 2'd3;
    @(negedge clk);
    idle_inputs();
    check("R2 write priority", lru_field, 6'b111000);
    check("R2 victim", victim_idx, 0);

    // R10: several idle cycles
    repeat (3) @(negedge clk);
    check("R10 hold", lru_field, 6'b111000);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 re-reset field", lru_field, 0);
    check("R1 re-reset victim", victim_idx, 3);

    done = 1'b1;
    finish_run();
  end
endmodule